// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block folds a wide field of level-sensitive interrupt lines into a much smaller set of group requests. Sources are bundled eight to a group. Each source has its own enable bit. A group request stays high for as long as at least one of its enabled sources is active. With the default parameters, 512 lines feed 64 group outputs.

Software controls the enables through a small 32-bit register window with separate read and write strobes. The enables are never written directly. One word sets enable bits and a second word clears them, so concurrent agents cannot race on a read-modify-write of the mask. Other words return the raw line state, the enabled-and-active state, and a two-word summary of which group requests are currently high.

A build parameter limits how many groups are live. Lines that belong to a group at or above that limit are dropped, so those groups never raise a request.

Top module: `grp_irq_merge`

## Requirements
- R1: Input line n belongs to group n/8 (integer division) and sits at bit n%8 inside that group's byte.
- R2: Each source's pending bit copies its input level at every rising clock edge. It is high while the line is high and low once the line is low, so it lags the input by one cycle.
- R3: Group output g is high exactly when (enable byte of g) AND (pending byte of g) is non-zero. It is registered and changes on the same edge that captures the input change or the enable write causing it.
- R4: The registers form quads of four words at a 16-byte stride. The quad at byte offset 16*q serves groups 4q to 4q+3. Group 4q+k occupies bits 8k+7:8k of every word in that quad.
- R5: Writing word 0 of a quad (offset +0x0) sets every enable bit where the data has a 1. Writing word 1 (offset +0x4) clears every enable bit where the data has a 1. Data bits that are 0 leave the enable unchanged.
- R6: Reading word 2 (offset +0x8) returns the raw pending bits of the quad's four groups. Reading word 3 (offset +0xC) returns pending AND enable. Reading word 0 or word 1 returns zero. Read data appears on bus_rdata in the cycle after bus_rd and is zero in any cycle without a read.
- R7: Offset 16*(NUM_GROUPS/4), which is 0x100 by default, reads a summary word in which bit i is the registered output of group i for groups 0 to 31. The next word, 0x104, holds groups 32 to 63 at bits 0 to 31. Bits for groups that do not exist read zero.
- R8: A write to word 2 or word 3 of any quad, to either summary word, or to any offset beyond the quads changes no enable bit. It raises bus_err for exactly the one cycle after the write.
- R9: A read at or beyond the end of the window, offset 0x108 by default, returns zero and raises bus_err for the one cycle after the read.
- R10: When LIVE_GROUPS is below NUM_GROUPS, lines of groups numbered LIVE_GROUPS and above never become pending and those group outputs stay low. Their enable bits are still stored.
- R11: Reset (rst_n low, asynchronous) clears all enables, pending bits, group outputs, bus_rdata and bus_err to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | NUM_GROUPS*8 (512) | Level-sensitive interrupt lines |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (9) | Byte offset into the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| bus_err | output | 1 | One-cycle pulse after an illegal access |
| grp_irq | output | NUM_GROUPS (64) | Registered group requests |

## Verification
Two functions can land on the same clock edge: an input line changing level, and an enable set or clear write aimed at that same line's group. They can occur in either order of effect. The bench provokes this with directed cases and with random cycles that both toggle lines and write enable words. Each resulting grp_irq value is judged against a bench model that applies the new levels and the new enables together. The bench also issues a read alongside a write in the same cycle and expects the read to return the state from before that write.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
    localparam int unsigned SRC_PER_GRP  = 8;
    localparam int unsigned GRP_PER_QUAD = 4;
    localparam int unsigned WORD_W       = 32;

    typedef enum logic [1:0] {
        QW_EN_SET = 2'd0,
        QW_EN_CLR = 2'd1,
        QW_RAW    = 2'd2,
        QW_MASKED = 2'd3
    } quad_word_e;

    typedef struct packed {
        logic       quad_hit;
        logic       sum_lo;
        logic       sum_hi;
        quad_word_e word;
    } acc_kind_t;
endpackage

// File: rtl/cmb_addr_decode.sv
module cmb_addr_decode
    import cmb_pkg::*;
#(
    parameter int unsigned ADDR_W    = 9,
    parameter int unsigned NUM_QUADS = 16,
    parameter int unsigned QIDX_W    = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_t         kind,
    output logic [QIDX_W-1:0] quad_idx
);
    localparam int unsigned SUM_BASE = NUM_QUADS * 16;

    always_comb begin
        kind          = '0;
        kind.word     = quad_word_e'(addr[3:2]);
        kind.quad_hit = ((32'(addr) >> 4) < NUM_QUADS);
        kind.sum_lo   = (32'(addr) == SUM_BASE);
        kind.sum_hi   = (32'(addr) == SUM_BASE + 4);
        quad_idx      = addr[QIDX_W+3:4];
    end
endmodule

// File: rtl/cmb_group_slice.sv
module cmb_group_slice
    import cmb_pkg::*;
#(
    parameter bit LIVE = 1'b1
) (
    input  logic [SRC_PER_GRP-1:0] raw_src,
    input  logic [SRC_PER_GRP-1:0] mask_q,
    input  logic                   set_en,
    input  logic                   clr_en,
    input  logic [SRC_PER_GRP-1:0] wbits,
    output logic [SRC_PER_GRP-1:0] mask_d,
    output logic [SRC_PER_GRP-1:0] pend_d,
    output logic                   hit_d
);
    always_comb begin
        mask_d = mask_q;
        if (set_en) mask_d = mask_d | wbits;
        if (clr_en) mask_d = mask_d & ~wbits;
        pend_d = LIVE ? raw_src : '0;
        hit_d  = |(mask_d & pend_d);
    end
endmodule

// File: rtl/cmb_read_mux.sv
module cmb_read_mux
    import cmb_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 64,
    parameter int unsigned QIDX_W     = 4
) (
    input  logic                                rd_en,
    input  acc_kind_t                           kind,
    input  logic [QIDX_W-1:0]                   quad_idx,
    input  logic [NUM_GROUPS*SRC_PER_GRP-1:0]   mask_q,
    input  logic [NUM_GROUPS*SRC_PER_GRP-1:0]   pend_q,
    input  logic [NUM_GROUPS-1:0]               grp_q,
    output logic [WORD_W-1:0]                   rd_data
);
    logic [2*WORD_W-1:0] sum_pad;
    logic [WORD_W-1:0]   raw_w;
    logic [WORD_W-1:0]   msk_w;

    always_comb begin
        sum_pad = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            sum_pad[g] = grp_q[g];
        end
        raw_w   = pend_q[quad_idx*WORD_W +: WORD_W];
        msk_w   = mask_q[quad_idx*WORD_W +: WORD_W];
        rd_data = '0;
        if (rd_en) begin
            if (kind.quad_hit) begin
                case (kind.word)
                    QW_RAW:    rd_data = raw_w;
                    QW_MASKED: rd_data = raw_w & msk_w;
                    default:   rd_data = '0;
                endcase
            end else if (kind.sum_lo) begin
                rd_data = sum_pad[WORD_W-1:0];
            end else if (kind.sum_hi) begin
                rd_data = sum_pad[2*WORD_W-1:WORD_W];
            end
        end
    end
endmodule

// File: rtl/grp_irq_merge.sv
module grp_irq_merge
    import cmb_pkg::*;
#(
    parameter int unsigned NUM_GROUPS  = 64,
    parameter int unsigned LIVE_GROUPS = 64,
    localparam int unsigned NUM_SRC    = NUM_GROUPS * SRC_PER_GRP,
    localparam int unsigned NUM_QUADS  = NUM_GROUPS / GRP_PER_QUAD,
    localparam int unsigned QIDX_W     = $clog2(NUM_QUADS),
    localparam int unsigned ADDR_W     = $clog2(NUM_QUADS * 16 + 8)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_in,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic                 bus_err,
    output logic [NUM_GROUPS-1:0] grp_irq
);
    typedef struct packed {
        logic [NUM_SRC-1:0]    mask;
        logic [NUM_SRC-1:0]    pend;
        logic [NUM_GROUPS-1:0] grp;
        logic [WORD_W-1:0]     rdata;
        logic                  err;
    } state_t;

    state_t st_d;
    state_t st_q;

    acc_kind_t             kind;
    logic [QIDX_W-1:0]     quad_idx;
    logic [NUM_SRC-1:0]    mask_nx;
    logic [NUM_SRC-1:0]    pend_nx;
    logic [NUM_GROUPS-1:0] hit_nx;
    logic [WORD_W-1:0]     rd_nx;
    logic                  legal_wr;
    logic                  legal_rd;

    cmb_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_QUADS(NUM_QUADS),
        .QIDX_W   (QIDX_W)
    ) u_dec (
        .addr    (bus_addr),
        .kind    (kind),
        .quad_idx(quad_idx)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic set_en;
        logic clr_en;
        assign set_en = bus_wr && kind.quad_hit && (kind.word == QW_EN_SET)
                        && (quad_idx == QIDX_W'(g / GRP_PER_QUAD));
        assign clr_en = bus_wr && kind.quad_hit && (kind.word == QW_EN_CLR)
                        && (quad_idx == QIDX_W'(g / GRP_PER_QUAD));

        cmb_group_slice #(
            .LIVE(g < LIVE_GROUPS)
        ) u_slice (
            .raw_src(src_in[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .mask_q (st_q.mask[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .set_en (set_en),
            .clr_en (clr_en),
            .wbits  (bus_wdata[(g % GRP_PER_QUAD)*SRC_PER_GRP +: SRC_PER_GRP]),
            .mask_d (mask_nx[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .pend_d (pend_nx[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .hit_d  (hit_nx[g])
        );
    end

    cmb_read_mux #(
        .NUM_GROUPS(NUM_GROUPS),
        .QIDX_W    (QIDX_W)
    ) u_rd (
        .rd_en   (bus_rd),
        .kind    (kind),
        .quad_idx(quad_idx),
        .mask_q  (st_q.mask),
        .pend_q  (st_q.pend),
        .grp_q   (st_q.grp),
        .rd_data (rd_nx)
    );

    always_comb begin
        legal_wr   = kind.quad_hit && ((kind.word == QW_EN_SET) || (kind.word == QW_EN_CLR));
        legal_rd   = kind.quad_hit || kind.sum_lo || kind.sum_hi;
        st_d       = st_q;
        st_d.mask  = mask_nx;
        st_d.pend  = pend_nx;
        st_d.grp   = hit_nx;
        st_d.rdata = rd_nx;
        st_d.err   = (bus_wr && !legal_wr) || (bus_rd && !legal_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grp_irq   = st_q.grp;
    assign bus_rdata = st_q.rdata;
    assign bus_err   = st_q.err;
endmodule

// File: rtl/cmb_checker.sv
module cmb_checker #(
    parameter int unsigned NUM_GROUPS  = 64,
    parameter int unsigned LIVE_GROUPS = 64,
    parameter int unsigned ADDR_W      = 9,
    localparam int unsigned NS         = NUM_GROUPS * 8,
    localparam int unsigned NQ         = NUM_GROUPS / 4,
    localparam int unsigned SUM_BASE   = NQ * 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NS-1:0]         src_in,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [31:0]           bus_rdata,
    input logic                  bus_err,
    input logic [NUM_GROUPS-1:0] grp_irq,
    input logic [NS-1:0]         mask_q,
    input logic [NS-1:0]         pend_q
);
    logic [NS-1:0]         live_src;
    logic [NUM_GROUPS-1:0] live_grp;
    logic [NUM_GROUPS-1:0] grp_ref;
    logic [63:0]           grp_pad;
    logic                  bad_wr;

    always_comb begin
        grp_pad = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            live_grp[g] = (g < LIVE_GROUPS);
            live_src[g*8 +: 8] = {8{live_grp[g]}};
            grp_ref[g] = |(mask_q[g*8 +: 8] & pend_q[g*8 +: 8]);
            grp_pad[g] = grp_irq[g];
        end
        bad_wr = bus_wr && (((32'(bus_addr) >> 4) >= NQ) || bus_addr[3]);
    end

    // R2: pending tracks the sampled level of live lines
    p_pend_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_q == $past(src_in & live_src)));

    // R3: group request equals OR of enabled pending bits
    p_grp_and_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grp_irq == grp_ref);

    // R6: enable words read as zero
    p_enword_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && ((32'(bus_addr) >> 4) < NQ) && !bus_addr[3]) |=> (bus_rdata == '0));

    // R7: low summary word reflects group requests
    p_sum_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (32'(bus_addr) == SUM_BASE)) |=> (bus_rdata == $past(grp_pad[31:0])));

    // R8: illegal write leaves enables alone and flags error
    p_bad_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> ($stable(mask_q) && bus_err));

    // R9: read past the window yields zero with error
    p_bad_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (32'(bus_addr) >= SUM_BASE + 8)) |=> (bus_err && bus_rdata == '0));

    // R10: dropped groups never request
    p_dead_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_irq & ~live_grp) == '0);
endmodule

bind grp_irq_merge cmb_checker #(
    .NUM_GROUPS (NUM_GROUPS),
    .LIVE_GROUPS(LIVE_GROUPS),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_in   (src_in),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .bus_err  (bus_err),
    .grp_irq  (grp_irq),
    .mask_q   (st_q.mask),
    .pend_q   (st_q.pend)
);

// File: tb/grp_irq_merge_tb.sv
module grp_irq_merge_tb;
    localparam int NG = 64;
    localparam int NS = NG * 8;
    localparam int LIM = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [8:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata, rdata_l;
    logic          err, err_l;
    logic [NG-1:0] grp, grp_l;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [NS-1:0] m_mask = '0;
    logic [NS-1:0] m_pend = '0;
    logic [NS-1:0] m_pend_l = '0;
    logic [NS-1:0] lim_src;

    always #10 clk = ~clk;

    grp_irq_merge #(.NUM_GROUPS(NG), .LIVE_GROUPS(NG)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_in(src), .bus_wr(wr), .bus_rd(rd),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_err(err),
        .grp_irq(grp));

    grp_irq_merge #(.NUM_GROUPS(NG), .LIVE_GROUPS(LIM)) u_dut_lim (
        .clk(clk), .rst_n(rst_n), .src_in(src), .bus_wr(wr), .bus_rd(rd),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_l), .bus_err(err_l),
        .grp_irq(grp_l));

    initial begin
        for (int i = 0; i < NS; i++) lim_src[i] = ((i / 8) < LIM);
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_grp(input logic [NS-1:0] mk, input logic [NS-1:0] pd);
        logic [63:0] r;
        r = '0;
        for (int g = 0; g < NG; g++) begin
            for (int b = 0; b < 8; b++) begin
                if (mk[8*g+b] && pd[8*g+b]) r[g] = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [NS-1:0] mk, input logic [NS-1:0] pd,
                                             input logic [63:0] g, input logic [8:0] a,
                                             input logic r);
        logic [31:0] v;
        int q;
        int w;
        v = '0;
        q = int'(a) / 16;
        w = (int'(a) / 4) % 4;
        if (!r) return '0;
        if (q < NG / 4) begin
            for (int k = 0; k < 4; k++) begin
                for (int b = 0; b < 8; b++) begin
                    if (w == 2) v[8*k+b] = pd[(4*q+k)*8+b];
                    if (w == 3) v[8*k+b] = pd[(4*q+k)*8+b] & mk[(4*q+k)*8+b];
                end
            end
        end else if (a == 9'h100) begin
            v = g[31:0];
        end else if (a == 9'h104) begin
            v = g[63:32];
        end
        return v;
    endfunction

    function automatic logic exp_err(input logic w_, input logic r_, input logic [8:0] a);
        int q;
        int w;
        logic e;
        q = int'(a) / 16;
        w = (int'(a) / 4) % 4;
        e = 1'b0;
        if (w_ && !(q < NG / 4 && w < 2)) e = 1'b1;
        if (r_ && !(q < NG / 4 || a == 9'h100 || a == 9'h104)) e = 1'b1;
        return e;
    endfunction

    // one bus cycle, called at a falling edge; checks results at the next falling edge
    task automatic cyc(input string tag, input logic [NS-1:0] s, input logic w_, input logic r_,
                       input logic [8:0] a, input logic [31:0] d);
        logic [31:0] er, erl;
        logic ee;
        int q;
        int w;
        src = s; wr = w_; rd = r_; addr = a; wdata = d;
        er  = exp_read(m_mask, m_pend, exp_grp(m_mask, m_pend), a, r_);
        erl = exp_read(m_mask, m_pend_l, exp_grp(m_mask, m_pend_l), a, r_);
        ee  = exp_err(w_, r_, a);
        q = int'(a) / 16;
        w = (int'(a) / 4) % 4;
        if (w_ && q < NG / 4 && w == 0) m_mask[q*32 +: 32] = m_mask[q*32 +: 32] | d;
        if (w_ && q < NG / 4 && w == 1) m_mask[q*32 +: 32] = m_mask[q*32 +: 32] & ~d;
        m_pend   = s;
        m_pend_l = s & lim_src;
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
        chk({tag, " R3 grp"}, 64'(grp), exp_grp(m_mask, m_pend));
        chk({tag, " R10 grp_lim"}, 64'(grp_l), exp_grp(m_mask, m_pend_l));
        chk({tag, " R6/R7 rdata"}, 64'(rdata), 64'(er));
        chk({tag, " R10 rdata_lim"}, 64'(rdata_l), 64'(erl));
        chk({tag, " R8/R9 err"}, 64'(err), 64'(ee));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        m_mask = '0; m_pend = '0; m_pend_l = '0;
        @(negedge clk);
        chk("R11 grp in reset", 64'(grp), 64'd0);
        chk("R11 rdata in reset", 64'(rdata), 64'd0);
        chk("R11 err in reset", 64'(err), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [NS-1:0] cur;
        logic [NS-1:0] ones;
        void'($urandom(32'h5EED_C0B1));
        ones = '1;
        repeat (2) @(negedge clk);
        do_reset();

        // R11: enables cleared, so all-high lines give no request
        cyc("R11 masks zero", ones, 1'b0, 1'b1, 9'h00C, 32'h0);
        cyc("R11 summary zero", ones, 1'b0, 1'b1, 9'h100, 32'h0);

        // R1/R4: line 203 -> group 25 bit 3 -> quad 6, bits 15:8, bit 11
        cur = '0; cur[203] = 1'b1;
        cyc("R1 single line", cur, 1'b0, 1'b0, 9'h000, 32'h0);
        cyc("R1 R4 raw read", cur, 1'b0, 1'b1, 9'h068, 32'h0);
        chk("R1 R4 bit 11", 64'(rdata), 64'h800);
        cyc("R5 enable bit", cur, 1'b1, 1'b0, 9'h060, 32'h0000_0800);
        chk("R3 group 25 high", 64'(grp[25]), 64'd1);
        cyc("R7 summary lo", cur, 1'b0, 1'b1, 9'h100, 32'h0);
        chk("R7 bit 25", 64'(rdata), 64'h0200_0000);
        cyc("R5 zero bits no effect", cur, 1'b1, 1'b1, 9'h064, 32'h0);
        cyc("R6 masked read", cur, 1'b0, 1'b1, 9'h06C, 32'h0);
        chk("R6 masked bit", 64'(rdata), 64'h800);
        cyc("R6 set word reads zero", cur, 1'b0, 1'b1, 9'h060, 32'h0);

        // same-edge: line falls while clear write lands, then rises with set
        cyc("R3 fall+clear", '0, 1'b1, 1'b0, 9'h064, 32'h0000_0800);
        cyc("R3 rise+set", cur, 1'b1, 1'b0, 9'h060, 32'h0000_0800);
        // read with write same cycle returns pre-write state
        cyc("R5 clr with read", cur, 1'b1, 1'b1, 9'h064, 32'h0000_0800);

        // R8: illegal writes leave enables clear
        cyc("R8 wr raw", ones, 1'b1, 1'b0, 9'h008, 32'hFFFF_FFFF);
        cyc("R8 wr masked", ones, 1'b1, 1'b0, 9'h00C, 32'hFFFF_FFFF);
        cyc("R8 wr sum lo", ones, 1'b1, 1'b0, 9'h100, 32'hFFFF_FFFF);
        cyc("R8 wr sum hi", ones, 1'b1, 1'b0, 9'h104, 32'hFFFF_FFFF);
        cyc("R8 wr beyond", ones, 1'b1, 1'b0, 9'h108, 32'hFFFF_FFFF);
        cyc("R8 readback", ones, 1'b0, 1'b1, 9'h00C, 32'h0);
        chk("R8 masked stays zero", 64'(rdata), 64'd0);
        cyc("R8 err gone", ones, 1'b0, 1'b0, 9'h000, 32'h0);
        chk("R8 err one cycle", 64'(err), 64'd0);

        // R9: reads past the window
        cyc("R9 rd 0x108", ones, 1'b0, 1'b1, 9'h108, 32'h0);
        cyc("R9 rd 0x1FC", ones, 1'b0, 1'b1, 9'h1FC, 32'h0);

        // R10: enable everything; limited copy must keep groups 16+ low
        for (int q = 0; q < NG / 4; q++) begin
            cyc("R10 enable all", ones, 1'b1, 1'b0, 9'(q * 16), 32'hFFFF_FFFF);
        end
        cyc("R10 summary hi", ones, 1'b0, 1'b1, 9'h104, 32'h0);
        chk("R10 limited hi zero", 64'(rdata_l), 64'd0);

        // random mix
        cur = '0;
        for (int it = 0; it < 3000; it++) begin
            logic [8:0] a;
            logic w_;
            logic r_;
            int sel;
            sel = $urandom_range(0, 15);
            if (sel == 0) begin
                for (int k = 0; k < NS / 32; k++) cur[k*32 +: 32] = $urandom();
            end else if (sel < 6) begin
                cur[$urandom_range(0, NS - 1)] ^= 1'b1;
            end
            w_ = ($urandom_range(0, 9) < 3);
            r_ = ($urandom_range(0, 9) < 5);
            if ($urandom_range(0, 9) == 0) a = 9'(9'h100 + 4 * $urandom_range(0, 3));
            else a = 9'(16 * $urandom_range(0, NG / 4 - 1) + 4 * $urandom_range(0, 3));
            cyc("rand", cur, w_, r_, a, $urandom() & $urandom());
        end

        // R11: reset mid-run clears enables
        do_reset();
        cyc("R11 after reset", ones, 1'b0, 1'b1, 9'h104, 32'h0);
        chk("R11 summary zero", 64'(rdata), 64'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule